// File: doc/BRIEF.md
# Quadrature Direction-Sensing Position Counter

This block keeps a running shaft position from a rotary encoder that delivers two square waves, A and B, a quarter period apart. Both channels are brought into the system clock domain through a chain of synchronizer flops. The block then watches the synchronized A channel for rising edges. At each such edge it captures the level of synchronized B as the rotation sense: B already high means the shaft turns clockwise, B low means counter-clockwise.

Every counted edge moves a binary position register up by one (clockwise) or down by one (counter-clockwise), wrapping modulo 2^CNT_W. A one-cycle step strobe marks each update, and the captured rotation sense is held on a direction output until the next counted edge. Reversing direction leaves the accumulated position untouched; only the synchronous reset clears it. The encoder inputs are expected to be low while reset is applied.

Top module: `qdc_position_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `position_o` becomes 0, `dir_o` becomes 0 and `step_o` becomes 0.
- R2: A rising edge of `enc_a` seen while `enc_b` is 1 raises `position_o` by one and sets `dir_o` to 1 (clockwise).
- R3: A rising edge of `enc_a` seen while `enc_b` is 0 lowers `position_o` by one and sets `dir_o` to 0 (counter-clockwise).
- R4: With `SYNC_STAGES` = 2, an `enc_a` rise set up before clock edge k shows up on `position_o`, `dir_o` and `step_o` after edge k+2; nothing changes after edges k and k+1.
- R5: `step_o` is high for exactly one clock cycle per counted `enc_a` rising edge and never for two cycles in a row.
- R6: A falling edge of `enc_a` and any edge of `enc_b` leave `position_o` and `dir_o` unchanged and raise no step.
- R7: Counting down from 0 gives all ones (0xFFFF at the default width).
- R8: Counting up from all ones gives 0.
- R9: A change in the rotation sense does not clear or disturb the accumulated position; the next step moves it by one from its present value.
- R10: Over any sequence of quadrature moves, `position_o` equals the number of clockwise edges minus the number of counter-clockwise edges, modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| position_o | output | CNT_W | Net shaft position, wrapping binary |
| dir_o | output | 1 | Rotation sense of the last counted edge, 1 = clockwise |
| step_o | output | 1 | One-cycle strobe for each position update |

## Verification
The bench drives quadrature sequences in both senses with random dwell times and random reversals, interleaved with lone B toggles that a design sampling the wrong channel or counting B edges would turn into extra steps. Directed cases start from reset and step once down and then once up, so a counter that saturates instead of wrapping shows 0 where 0xFFFF is expected. A cycle-exact latency probe catches a design with a missing or extra synchronizer stage, and a step-pulse monitor catches a strobe that lasts two cycles or fires on falling A edges.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

   typedef enum logic {
      DIR_CCW = 1'b0,
      DIR_CW  = 1'b1
   } qdc_dir_e;

   typedef struct packed {
      logic a;
      logic b;
   } qdc_pair_t;

   localparam int QDC_MIN_SYNC = 2;
   localparam int QDC_MIN_CNT_W = 2;

endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import qdc_pkg::*;

   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < QDC_MIN_SYNC) begin : g_bad_stages
         $error("qdc_sync: STAGES below minimum");
      end
      if (W < 1) begin : g_bad_width
         $error("qdc_sync: W must be positive");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[0] <= '0;
               else     stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[i] <= '0;
               else     stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/qdc_edge.sv
module qdc_edge (
   input  logic clk,
   input  logic rst,
   input  logic a_s,
   input  logic b_s,
   output logic rise_o,
   output logic up_o,
   output logic dir_o
);
   import qdc_pkg::*;

   logic     a_d;
   qdc_dir_e dir_q;

   always_ff @(posedge clk) begin
      if (rst) a_d <= 1'b0;
      else     a_d <= a_s;
   end

   assign rise_o = a_s & ~a_d;
   assign up_o   = b_s;

   always_ff @(posedge clk) begin
      if (rst)         dir_q <= DIR_CCW;
      else if (rise_o) dir_q <= qdc_dir_e'(b_s);
   end

   assign dir_o = dir_q;

   // R5: an A rise lasts one cycle only
   a_r5_rise_single : assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);

   // R6: direction holds without an A rise
   a_r6_dir_hold : assert property (@(posedge clk) disable iff (rst)
      (!$past(rise_o) && !$past(rst)) |-> $stable(dir_q));

endmodule

// File: rtl/qdc_updown.sv
module qdc_updown #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic             up_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             step_o
);
   import qdc_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < QDC_MIN_CNT_W) begin : g_bad_width
         $error("qdc_updown: CNT_W below minimum");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             step_q;
   logic             up_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         step_q <= 1'b0;
         up_q   <= 1'b0;
      end else begin
         step_q <= step_i;
         if (step_i) begin
            up_q  <= up_i;
            cnt_q <= up_i ? cnt_q + ONE : cnt_q - ONE;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign step_o = step_q;

   // R2 R3 R7 R8: each strobe moves the count by exactly one, wrapping
   a_r2_r3_step_by_one : assert property (@(posedge clk) disable iff (rst)
      step_q |-> (up_q ? (cnt_q == $past(cnt_q) + ONE)
                       : (cnt_q == $past(cnt_q) - ONE)));

   // R6 R9: no strobe, no movement
   a_r9_count_hold : assert property (@(posedge clk) disable iff (rst)
      (!step_q && !$past(rst)) |-> $stable(cnt_q));

   // R5: strobe never spans two cycles
   a_r5_step_single : assert property (@(posedge clk) disable iff (rst)
      step_q |=> !step_q);

endmodule

// File: rtl/qdc_position_counter.sv
module qdc_position_counter #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enc_a,
   input  logic             enc_b,
   output logic [CNT_W-1:0] position_o,
   output logic             dir_o,
   output logic             step_o
);
   import qdc_pkg::*;

   qdc_pair_t raw, syn;
   logic      rise, up;

   assign raw.a = enc_a;
   assign raw.b = enc_b;

   qdc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (syn)
   );

   qdc_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .a_s    (syn.a),
      .b_s    (syn.b),
      .rise_o (rise),
      .up_o   (up),
      .dir_o  (dir_o)
   );

   qdc_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .step_i (rise),
      .up_i   (up),
      .cnt_o  (position_o),
      .step_o (step_o)
   );

   // R2 R3: the flag shown with a strobe is B as sampled at the A rise
   a_r2_dir_matches_b : assert property (@(posedge clk) disable iff (rst)
      step_o |-> (dir_o == $past(syn.b)));

   // R3: down steps are reported with the counter-clockwise flag
   a_r3_down_flag : assert property (@(posedge clk) disable iff (rst)
      (step_o && (position_o == $past(position_o) - CNT_W'(1)) && CNT_W > 1
       && (position_o != $past(position_o) + CNT_W'(1))) |-> !dir_o);

endmodule

// File: tb/tb_qdc_position_counter.sv
module tb_qdc_position_counter;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam int HOLD = 5;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         enc_a = 1'b0;
   logic         enc_b = 1'b0;
   logic [W-1:0] position_o;
   logic         dir_o;
   logic         step_o;

   int compared = 0;
   int mismatched = 0;
   int exp_steps = 0;
   int seen_steps = 0;
   logic step_prev = 1'b0;
   logic [W-1:0] exp_pos = '0;
   logic exp_dir = 1'b0;
   logic cur_a = 1'b0;
   logic cur_b = 1'b0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qdc_position_counter #(.CNT_W(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
      .position_o(position_o), .dir_o(dir_o), .step_o(step_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] next_pos(input logic [W-1:0] p, input logic up);
      return up ? p + 1'b1 : p - 1'b1;
   endfunction

   // R5 monitor: strobe width and total strobes
   always @(negedge clk) begin
      if (!rst) begin
         if (step_o) seen_steps++;
         if (step_o && step_prev) check("R5 double strobe", 1, 0);
         step_prev = step_o;
      end else begin
         step_prev = 1'b0;
      end
   end

   // apply new levels, update the model, wait for settling
   task automatic drive(input logic a, input logic b, input int dwell);
      @(negedge clk);
      if (a && !cur_a) begin
         exp_pos = next_pos(exp_pos, b);
         exp_dir = b;
         exp_steps++;
      end
      cur_a = a;
      cur_b = b;
      enc_a = a;
      enc_b = b;
      repeat (dwell) @(negedge clk);
   endtask

   task automatic quad_step(input bit cw, input int dwell);
      // CW: B leads A (00 01 11 10); CCW: A leads B (00 10 11 01)
      if (cw) begin
         drive(1'b0, 1'b1, dwell); drive(1'b1, 1'b1, dwell);
         drive(1'b1, 1'b0, dwell); drive(1'b0, 1'b0, dwell);
      end else begin
         drive(1'b1, 1'b0, dwell); drive(1'b1, 1'b1, dwell);
         drive(1'b0, 1'b1, dwell); drive(1'b0, 1'b0, dwell);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int pre;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check("R1 position in reset", position_o, 0);
      check("R1 dir in reset", dir_o, 0);
      check("R1 step in reset", step_o, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 position after reset", position_o, 0);

      // R7: one CCW step from zero wraps to all ones
      quad_step(1'b0, HOLD);
      check("R7 wrap down", position_o, 32'h0000FFFF);
      check("R3 dir ccw", dir_o, 0);
      // R8: one CW step from all ones wraps to zero
      quad_step(1'b1, HOLD);
      check("R8 wrap up", position_o, 0);
      check("R2 dir cw", dir_o, 1);

      // R4: exact latency of an A rise with B high
      drive(1'b0, 1'b1, HOLD);
      pre = position_o;
      @(negedge clk);
      enc_a = 1'b1; cur_a = 1'b1;
      exp_pos = next_pos(exp_pos, 1'b1); exp_dir = 1'b1; exp_steps++;
      @(negedge clk);
      check("R4 no change after edge k", position_o, pre);
      check("R4 no strobe after edge k", step_o, 0);
      @(negedge clk);
      check("R4 no change after edge k+1", position_o, pre);
      @(negedge clk);
      check("R4 position after edge k+2", position_o, exp_pos);
      check("R4 strobe after edge k+2", step_o, 1);
      @(negedge clk);
      check("R5 strobe ends", step_o, 0);
      // R6: falling A and B toggles do nothing
      drive(1'b0, 1'b1, HOLD);
      check("R6 falling A", position_o, exp_pos);
      drive(1'b0, 1'b0, HOLD);
      drive(1'b0, 1'b1, HOLD);
      drive(1'b0, 1'b0, HOLD);
      check("R6 B toggles position", position_o, exp_pos);
      check("R6 B toggles dir", dir_o, 1);

      // R9: reversal keeps the count
      repeat (3) quad_step(1'b1, HOLD);
      check("R9 before reversal", position_o, exp_pos);
      quad_step(1'b0, HOLD);
      check("R9 after reversal", position_o, exp_pos);
      check("R3 dir after reversal", dir_o, 0);

      // R10: random quadrature walk with stray B glitches
      for (int i = 0; i < 300; i++) begin
         bit cw = $urandom_range(0, 1) == 1;
         int dw = $urandom_range(HOLD, HOLD + 3);
         quad_step(cw, dw);
         if ($urandom_range(0, 3) == 0) begin
            drive(1'b0, 1'b1, dw);
            drive(1'b0, 1'b0, dw);
         end
         check("R10 net position", position_o, exp_pos);
         check(cw ? "R2 random dir" : "R3 random dir", dir_o, exp_dir);
      end
      repeat (HOLD) @(negedge clk);
      check("R5 strobe total", seen_steps, exp_steps);

      // R1: reset mid-run clears the count
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset clears position", position_o, 0);
      check("R1 reset clears dir", dir_o, 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule